// File: doc/BRIEF.md
# MDIO Management Master

This block lets software reach PHY registers over a two-wire management bus (MDC clock, bidirectional MDIO data) using clause-22 frames. Software sees six 32-bit registers, selected by a 3-bit word index. These are: configuration, command, address, write data, read data and flags. It writes the target PHY and register number into the address register. Writing the write-data register then starts a write frame. A read frame starts when the command bit goes from 0 to 1. Software polls the flags until the transaction has ended and then collects the read value.

MDC is derived from the system clock. Each half period lasts `(div + 1) * BASE` system clocks, where `div` is a 3-bit field in the configuration register. MDC runs only while a frame is in flight and rests low otherwise. A self-clearing soft-reset bit in the configuration register aborts any frame and returns the sequencer to idle.

Top module: `mdio_mgmt_master`

## Requirements
- R1: A write frame shifts out 64 bits, MSB first, with the output enable high throughout. The bits are: 32 ones, `01`, opcode `01`, the 5-bit PHY address (address register bits 12:8), the 5-bit register number (address register bits 4:0), turnaround `10`, then the 16 data bits.
- R2: When the block is idle, a write to the write-data register (index 3) starts a write frame. BUSY (flags bit 0) reads 1 from the next cycle until the frame ends.
- R3: A read frame starts only when a command-register (index 1) write changes bit 0 from 0 to 1. Writing 1 while the stored bit is already 1 starts nothing.
- R4: A read frame drives 32 ones, `01`, opcode `10`, PHY address and register number (bits 0..45), then releases MDIO for bits 46..63. MDIO is sampled at each MDC rising edge during bits 48..63. The 16 sampled bits, MSB first, appear in the read-data register (index 4, bits 15:0).
- R5: NOTVALID (flags bit 2) is set when a read starts. It clears in the same cycle the read value is captured, which is the same cycle BUSY clears. NOTVALID is never 1 while BUSY is 0.
- R6: While a frame runs, each MDC half period lasts `(div + 1) * BASE` system clocks, with `div` taken from configuration bits 2:0. MDC is low whenever the block is idle.
- R7: Writing configuration (index 0) with bit 31 set aborts any frame. From the next cycle BUSY, NOTVALID, MDC and the output enable are all 0. Bit 31 always reads back 0, and bits 2:0 of the same write become the new divider.
- R8: A write-data write or a read command that arrives while BUSY is 1 is ignored. The frame in flight is unchanged, the write-data register keeps its value, NOTVALID is not set, and no further frame follows.
- R9: After reset the flags read 0, the configuration reads 7, the read data reads 0, and MDC and the output enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index (0 cfg, 1 cmd, 2 addr, 3 wdata, 4 rdata, 5 flags) |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Register read value for `reg_addr`, combinational |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
A wrong bit counter or a wrong shift register shows up on the MDIO pins within a single frame. The bench therefore collects every frame at the MDC rising edges and compares it, bit by bit, with the frame it expects, including the output enable. A stuck pending flag or a lost capture shows up at the flags and read-data registers as soon as BUSY drops. A wrong divider shows up in the first MDC half period. A sequencer that is not cleared by soft reset shows up as MDC toggling, or BUSY staying set, one cycle after the reset write.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int FRAME_LEN = 64;
    localparam int TURN_BIT  = 46;
    localparam int DATA_BIT  = 48;

    localparam logic [2:0] RA_CFG  = 3'd0;
    localparam logic [2:0] RA_CMD  = 3'd1;
    localparam logic [2:0] RA_ADDR = 3'd2;
    localparam logic [2:0] RA_WDAT = 3'd3;
    localparam logic [2:0] RA_RDAT = 3'd4;
    localparam logic [2:0] RA_FLAG = 3'd5;

    typedef struct packed {
        logic        rd;
        logic [4:0]  phy;
        logic [4:0]  regn;
        logic [15:0] data;
    } mgmt_req_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_DRIVE,
        PH_RELEASE
    } bus_phase_e;

    function automatic logic [FRAME_LEN-1:0] frame_bits(input mgmt_req_t r);
        return {32'hFFFF_FFFF, 2'b01, (r.rd ? 2'b10 : 2'b01), r.phy, r.regn,
                2'b10, (r.rd ? 16'hFFFF : r.data)};
    endfunction

endpackage

// File: rtl/mdio_mgmt_clkgen.sv
module mdio_mgmt_clkgen #(
    parameter int DIV_W = 3,
    parameter int BASE  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tk,
    output logic             fall_tk
);
    localparam int CNT_W = $clog2((2 ** DIV_W) * BASE + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_m1;
    logic             wrap;

    assign half_m1 = CNT_W'((32'(div) + 32'd1) * 32'(BASE) - 32'd1);
    assign wrap    = run && (cnt_q == half_m1);
    assign rise_tk = wrap && !mdc;
    assign fall_tk = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= !mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_mgmt_seq.sv
module mdio_mgmt_seq
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  mgmt_req_t   req,
    input  logic        rise_tk,
    input  logic        fall_tk,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rd_val
);
    localparam int BIT_W = $clog2(FRAME_LEN);

    logic                 busy_q;
    logic                 rd_q;
    logic [FRAME_LEN-1:0] sh_q;
    logic [BIT_W-1:0]     bit_q;
    logic [15:0]          cap_q;
    bus_phase_e           phase;

    always_comb begin
        if (!busy_q)
            phase = PH_IDLE;
        else if (rd_q && (bit_q >= BIT_W'(TURN_BIT)))
            phase = PH_RELEASE;
        else
            phase = PH_DRIVE;
    end

    assign busy    = busy_q;
    assign done    = busy_q && fall_tk && (bit_q == BIT_W'(FRAME_LEN - 1));
    assign mdio_oe = (phase == PH_DRIVE);
    assign mdio_o  = (phase == PH_DRIVE) ? sh_q[FRAME_LEN-1] : 1'b1;
    assign rd_val  = cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            rd_q   <= 1'b0;
            sh_q   <= '1;
            bit_q  <= '0;
            cap_q  <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            rd_q   <= req.rd;
            sh_q   <= frame_bits(req);
            bit_q  <= '0;
        end else if (busy_q) begin
            if (rise_tk && rd_q && (bit_q >= BIT_W'(DATA_BIT)))
                cap_q <= {cap_q[14:0], mdio_i};
            if (fall_tk) begin
                if (bit_q == BIT_W'(FRAME_LEN - 1)) begin
                    busy_q <= 1'b0;
                end else begin
                    sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b1};
                    bit_q <= bit_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W   = 3,
    parameter int DIV_RST = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             busy,
    input  logic             done,
    input  logic [15:0]      rd_val,
    output logic             start,
    output mgmt_req_t        req,
    output logic             sreset,
    output logic             pending,
    output logic [DIV_W-1:0] div
);
    logic [DIV_W-1:0] div_q;
    logic             cmd_q;
    logic [4:0]       phy_q;
    logic [4:0]       regn_q;
    logic [15:0]      wdat_q;
    logic [15:0]      rdat_q;
    logic             pend_q;
    logic             start_wr;
    logic             start_rd;

    assign sreset   = reg_we && (reg_addr == RA_CFG) && reg_wdata[31];
    assign start_wr = reg_we && (reg_addr == RA_WDAT) && !busy;
    assign start_rd = reg_we && (reg_addr == RA_CMD) && reg_wdata[0] && !cmd_q && !busy;
    assign start    = start_wr || start_rd;
    assign pending  = pend_q;
    assign div      = div_q;

    always_comb begin
        req.rd   = start_rd;
        req.phy  = phy_q;
        req.regn = regn_q;
        req.data = reg_wdata[15:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= DIV_W'(DIV_RST);
            cmd_q  <= 1'b0;
            phy_q  <= '0;
            regn_q <= '0;
            wdat_q <= '0;
            rdat_q <= '0;
            pend_q <= 1'b0;
        end else begin
            if (reg_we) begin
                case (reg_addr)
                    RA_CFG:  div_q <= reg_wdata[DIV_W-1:0];
                    RA_CMD:  cmd_q <= reg_wdata[0];
                    RA_ADDR: begin
                        phy_q  <= reg_wdata[12:8];
                        regn_q <= reg_wdata[4:0];
                    end
                    RA_WDAT: if (!busy) wdat_q <= reg_wdata[15:0];
                    default: ;
                endcase
            end
            if (sreset) begin
                pend_q <= 1'b0;
                cmd_q  <= 1'b0;
            end else if (start_rd) begin
                pend_q <= 1'b1;
            end else if (done && pend_q) begin
                pend_q <= 1'b0;
                rdat_q <= rd_val;
            end
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CFG:  reg_rdata = 32'(div_q);
            RA_CMD:  reg_rdata = {31'd0, cmd_q};
            RA_ADDR: reg_rdata = {19'd0, phy_q, 3'd0, regn_q};
            RA_WDAT: reg_rdata = {16'd0, wdat_q};
            RA_RDAT: reg_rdata = {16'd0, rdat_q};
            RA_FLAG: reg_rdata = {29'd0, pend_q, 1'b0, busy};
            default: reg_rdata = 32'd0;
        endcase
    end

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W   = 3,
    parameter int DIV_RST = 7,
    parameter int BASE    = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);
    logic             seq_busy;
    logic             seq_done;
    logic             rd_pending;
    logic             sreset;
    logic             core_rst;
    logic             start;
    logic             rise_tk;
    logic             fall_tk;
    logic [15:0]      rd_val;
    logic [DIV_W-1:0] div;
    mgmt_req_t        req;

    assign core_rst = rst || sreset;

    mdio_mgmt_regs #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(seq_busy),
        .done(seq_done), .rd_val(rd_val), .start(start), .req(req),
        .sreset(sreset), .pending(rd_pending), .div(div)
    );

    mdio_mgmt_clkgen #(.DIV_W(DIV_W), .BASE(BASE)) u_clk (
        .clk(clk), .rst(core_rst), .run(seq_busy), .div(div),
        .mdc(mdc), .rise_tk(rise_tk), .fall_tk(fall_tk)
    );

    mdio_mgmt_seq u_seq (
        .clk(clk), .rst(core_rst), .start(start), .req(req),
        .rise_tk(rise_tk), .fall_tk(fall_tk), .mdio_i(mdio_i),
        .busy(seq_busy), .done(seq_done), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .rd_val(rd_val)
    );

endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk
    import mdio_mgmt_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        reg_we,
    input logic [2:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        busy,
    input logic        notvalid,
    input logic        done,
    input logic        mdc,
    input logic        mdio_oe
);
    AST_NOTVALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        notvalid |-> busy); // R5

    AST_DONE_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        done |=> (!busy && !notvalid)); // R5

    AST_WR_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == RA_WDAT && !busy) |=> busy); // R2

    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc); // R6

    AST_MDC_NO_GLITCH: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdc) |=> $stable(mdc)); // R6

    AST_SRST_IDLES: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == RA_CFG && reg_wdata[31])
        |=> (!busy && !notvalid && !mdc && !mdio_oe)); // R7

    AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && reg_we && reg_addr == RA_WDAT) |=> busy); // R8

    AST_OE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> busy); // R9

endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(seq_busy), .notvalid(rd_pending),
    .done(seq_done), .mdc(mdc), .mdio_oe(mdio_oe)
);

// File: tb/mdio_mgmt_master_test.sv
`timescale 1ns/1ps
module mdio_mgmt_master_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_i = 1'b1;
    logic        mdio_o;
    logic        mdio_oe;

    always #2 clk = !clk;

    mdio_mgmt_master uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    typedef struct {
        bit        rd;
        bit [4:0]  phy;
        bit [4:0]  rg;
        bit [15:0] d;
    } exp_t;

    exp_t        exp_q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    int          mon_k = 0;
    logic [63:0] mon_bits;
    logic [63:0] mon_oe;
    logic [15:0] phy_val = 16'h0000;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // Scoreboard monitor: collect one bit per MDC rising edge.
    task automatic check_frame();
        exp_t        e;
        logic [63:0] want;
        logic [63:0] mask;
        if (exp_q.size() == 0) begin
            chk("R8 unexpected frame", 32'd1, 32'd0);
            return;
        end
        e = exp_q.pop_front();
        want = {32'hFFFF_FFFF, 2'b01, (e.rd ? 2'b10 : 2'b01), e.phy, e.rg, 2'b10, e.d};
        if (e.rd) begin
            mask = {{46{1'b1}}, 18'd0};
            chk("R4 read frame header", 32'((mon_bits & mask) == (want & mask)), 32'd1);
            chk("R4 read frame release", 32'(mon_oe == mask), 32'd1);
        end else begin
            chk("R1 write frame bits", 32'(mon_bits == want), 32'd1);
            chk("R1 write frame enable", 32'(mon_oe == '1), 32'd1);
        end
    endtask

    always @(posedge mdc) begin
        #1;
        mon_bits[63 - mon_k] = mdio_o;
        mon_oe[63 - mon_k]   = mdio_oe;
        mon_k++;
        if (mon_k == 64) begin
            mon_k = 0;
            check_frame();
        end
    end

    // PHY model: present the next bit after each MDC falling edge.
    always @(negedge mdc) begin
        if (mon_k >= 48 && mon_k < 64)
            mdio_i = phy_val[63 - mon_k];
        else
            mdio_i = 1'b1;
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic push(input bit r, input bit [4:0] p, input bit [4:0] g, input bit [15:0] d);
        exp_t e;
        e.rd = r; e.phy = p; e.rg = g; e.d = d;
        exp_q.push_back(e);
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd5, v);
            if (v[0] == 1'b0) return;
        end
        chk({req, " idle timeout"}, 32'd1, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk("watchdog", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int          n;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R9 reset state
        rd(3'd5, v); chk("R9 flags", v, 32'd0);
        rd(3'd0, v); chk("R9 cfg divider", v, 32'd7);
        rd(3'd4, v); chk("R9 rdata", v, 32'd0);
        chk("R9 mdc", 32'(mdc), 32'd0);
        chk("R9 oe", 32'(mdio_oe), 32'd0);

        // R7 divider field
        wr(3'd0, 32'd0);
        rd(3'd0, v); chk("R7 divider write", v, 32'd0);

        // R1 / R2 write frame
        wr(3'd2, (32'h11 << 8) | 32'h05);
        push(1'b0, 5'h11, 5'h05, 16'hA5C3);
        wr(3'd3, 32'h0000_A5C3);
        rd(3'd5, v); chk("R2 busy after launch", v, 32'd1);
        wait_idle("R2");
        chk("R1 frame consumed", 32'(exp_q.size()), 32'd0);

        // R6 half period with div=2 -> 24 clocks
        wr(3'd0, 32'd2);
        wr(3'd2, (32'h03 << 8) | 32'h1F);
        push(1'b0, 5'h03, 5'h1F, 16'h0001);
        wr(3'd3, 32'h0000_0001);
        @(posedge mdc);
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (mdc);
        chk("R6 half period", 32'(n), 32'd24);
        wait_idle("R6");
        chk("R6 mdc idle low", 32'(mdc), 32'd0);
        wr(3'd0, 32'd0);

        // R3 / R4 / R5 read
        phy_val = 16'h3C96;
        wr(3'd2, (32'h1A << 8) | 32'h02);
        wr(3'd1, 32'd0);
        push(1'b1, 5'h1A, 5'h02, 16'h0000);
        wr(3'd1, 32'd1);
        rd(3'd5, v); chk("R5 busy and notvalid", v, 32'd5);
        wait_idle("R5");
        rd(3'd5, v); chk("R5 flags clear", v, 32'd0);
        rd(3'd4, v); chk("R4 read value", v, 32'h0000_3C96);

        // R3 holding the bit at 1
        wr(3'd1, 32'd1);
        repeat (20) @(posedge clk);
        #1;
        rd(3'd5, v); chk("R3 no relaunch", v, 32'd0);
        chk("R3 no mdc activity", 32'(mon_k), 32'd0);

        // R4 second read, different value
        phy_val = 16'h8001;
        wr(3'd1, 32'd0);
        push(1'b1, 5'h1A, 5'h02, 16'h0000);
        wr(3'd1, 32'd1);
        wait_idle("R4");
        rd(3'd4, v); chk("R4 second read value", v, 32'h0000_8001);

        // R8 commands while busy
        wr(3'd1, 32'd0);
        push(1'b0, 5'h1A, 5'h02, 16'h1234);
        wr(3'd3, 32'h0000_1234);
        repeat (100) @(posedge clk);
        wr(3'd3, 32'h0000_FFFF);
        rd(3'd3, v); chk("R8 wdata kept", v, 32'h0000_1234);
        wr(3'd1, 32'd1);
        rd(3'd5, v); chk("R8 read not launched", v, 32'd1);
        wait_idle("R8");
        repeat (300) @(posedge clk);
        #1;
        chk("R8 no extra frame", 32'(mon_k), 32'd0);
        chk("R8 queue drained", 32'(exp_q.size()), 32'd0);

        // R7 soft reset mid-frame
        push(1'b0, 5'h1A, 5'h02, 16'h0F0F);
        wr(3'd3, 32'h0000_0F0F);
        repeat (300) @(posedge clk);
        wr(3'd0, 32'h8000_0000);
        rd(3'd5, v); chk("R7 flags after abort", v, 32'd0);
        chk("R7 mdc after abort", 32'(mdc), 32'd0);
        chk("R7 oe after abort", 32'(mdio_oe), 32'd0);
        rd(3'd0, v); chk("R7 reset bit reads 0", v, 32'd0);
        void'(exp_q.pop_back());
        mon_k = 0;
        repeat (100) @(posedge clk);
        #1;
        chk("R7 bus stays quiet", 32'(mon_k), 32'd0);
        push(1'b0, 5'h1A, 5'h02, 16'h5A5A);
        wr(3'd3, 32'h0000_5A5A);
        wait_idle("R7");
        chk("R7 frame after abort", 32'(exp_q.size()), 32'd0);

        finish_run();
    end

endmodule